// File: doc/BRIEF.md
# Cache-Line Address Sequencer

This block produces the request address streams for a memory traffic test. Software programs a source base, a destination base, a line count and a set of mode bits. Once the start bit is set, two independent channels run side by side. The read channel walks the source buffer one cache line at a time, and the write channel walks the destination buffer in the same way. Addresses are line addresses, where one unit stands for 64 bytes. Each address is formed by OR-ing a running line index into a base that is aligned to the index range.

Each channel waits while its almost-full input is high, and it can insert random idle gaps between requests. A run either ends after the programmed number of lines, with a one-cycle done pulse, or wraps back to index zero indefinitely. A wrapping run stops only when the error input is raised or software clears the start bit. The read request type comes from a 2-bit selector, and one of its codes rotates through the three fixed kinds. The write request type is a single mode bit.

Configuration writes use `cfg_sel` to pick the target: 0 source base, 1 destination base, 2 line count, 3 mode, 4 control. The mode word fields are: bit 0 wrap, bit 1 write-through, bit 2 delay enable, and bits 4:3 read-type selector. Bit 0 of the control word is the start bit.

Top module: `cls_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `rd_valid`, `wr_valid` and `done` are all low.
- R2: With delay disabled and no backpressure, a started run with line count C drives one read per cycle at line addresses src|0 through src|(C-1), in order. The write channel drives dst|0 through dst|(C-1) in the same way. The first request appears in the second cycle after the start write.
- R3: A channel issues no request in a cycle that follows a clock edge at which its almost-full input was high, and its index does not advance then. The two channels stall independently.
- R4: In non-wrap mode, once both channels have issued C lines, `done` is high for exactly one cycle and the start bit clears. No further requests follow.
- R5: In wrap mode (mode bit 0 = 1), the index returns to 0 after C-1, `done` never pulses, and requests continue until the start bit is cleared.
- R6: Read type selector (mode bits 4:3): codes 0 (shared), 1 (invalid) and 2 (owned) give that `rd_type` on every read. Code 3 gives 0,1,2,0,1,2,... starting at 0 on each start.
- R7: `wr_type` equals mode bit 1 on every write: 0 is write-back, 1 is write-through.
- R8: With delay enabled (mode bit 2 = 1), a channel that is not stalled leaves between 0 and 7 idle cycles between consecutive requests. Some gaps are non-zero, and the line count and address order are unchanged.
- R9: While the start bit is set, writes to the base, count and mode registers are ignored.
- R10: The low 14 bits (index width) of a written base are ignored. Only the low 14 bits of the written line count are used.
- R11: Starting with a line count of 0 issues no requests and gives one `done` pulse.
- R12: `halt_err` high during a run ends it after at most one more request per channel, without a `done` pulse. The start bit clears and no requests are issued while it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 src, 1 dst, 2 count, 3 mode, 4 control |
| cfg_wdata | input | 32 | Configuration write data |
| rd_full | input | 1 | Read channel almost-full |
| wr_full | input | 1 | Write channel almost-full |
| halt_err | input | 1 | Error stop |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | 32 | Read line address |
| rd_type | output | 2 | Read request type |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | 32 | Write line address |
| wr_type | output | 1 | Write request type |
| done | output | 1 | Run completion pulse |

## Verification
Several rules are checked by the assertions on every cycle. No request may follow an almost-full edge. Every issued index must stay below the line count, and no request may follow a finished channel or an idle start bit. `done` may never last more than one cycle, configuration registers must hold during a run, and the gap generator must never lock up. The bench scenarios are needed for the behaviour that only shows across a whole run: the exact address order, wrap-around, the type rotation, the random gap spread, the masking of base and count bits, and the cycle counts around stall, stop and error.

// File: rtl/cls_pkg.sv
package cls_pkg;
  typedef enum logic [2:0] {
    SEL_SRC  = 3'd0,
    SEL_DST  = 3'd1,
    SEL_CNT  = 3'd2,
    SEL_MODE = 3'd3,
    SEL_CTRL = 3'd4
  } cfg_sel_e;

  typedef enum logic [1:0] {
    RD_SHARED = 2'd0,
    RD_INVAL  = 2'd1,
    RD_OWNED  = 2'd2,
    RD_MIXED  = 2'd3
  } rd_kind_e;

  localparam int MODE_W    = 5;
  localparam int MODE_WRAP = 0;
  localparam int MODE_WT   = 1;
  localparam int MODE_DLY  = 2;
  localparam int MODE_RSEL = 3;   // two bits: 4:3
  localparam int GAP_W     = 3;
  localparam int NUM_CH    = 2;   // 0 = read, 1 = write
endpackage

// File: rtl/cls_lfsr.sv
module cls_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] state
);
  logic fb;
  assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];

  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= {state[14:0], fb};
  end

  assert_lfsr_live_R8: assert property (@(posedge clk) disable iff (rst)
    state != 16'h0);
endmodule

// File: rtl/cls_chan.sv
module cls_chan import cls_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              clr,
  input  logic              wrap,
  input  logic              full,
  input  logic              dly_en,
  input  logic [GAP_W-1:0]  gap_seed,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  cnt,
  output logic              fire,
  output logic              req_v,
  output logic [ADDR_W-1:0] req_addr,
  output logic              fin
);
  logic [IDX_W-1:0] idx;
  logic [GAP_W-1:0] gap;
  logic             last;

  assign last = ({1'b0, idx} + 1'b1) == {1'b0, cnt};
  assign fire = go && !fin && !full && (gap == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      gap      <= '0;
      fin      <= 1'b0;
      req_v    <= 1'b0;
      req_addr <= '0;
    end else begin
      req_v <= fire;
      if (clr) begin
        idx <= '0;
        gap <= '0;
        fin <= (cnt == '0);
      end else if (fire) begin
        req_addr <= base | ADDR_W'(idx);
        gap      <= dly_en ? gap_seed : '0;
        if (last) begin
          idx <= '0;
          fin <= !wrap;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (gap != '0) begin
        gap <= gap - 1'b1;
      end
    end
  end

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
    req_v |-> !$past(full));
  assert_idx_bound_R2: assert property (@(posedge clk) disable iff (rst)
    req_v |-> (req_addr[IDX_W-1:0] < cnt));
  assert_quiet_after_fin_R4: assert property (@(posedge clk) disable iff (rst)
    fin |=> !req_v);
endmodule

// File: rtl/cls_seq.sv
module cls_seq import cls_pkg::*; #(
  parameter int          ADDR_W = 32,
  parameter int          IDX_W  = 14,
  parameter logic [15:0] SEED   = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              rd_full,
  input  logic              wr_full,
  input  logic              halt_err,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_type,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_type,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LOW_MASK = {{(ADDR_W-IDX_W){1'b0}}, {IDX_W{1'b1}}};

  logic [ADDR_W-1:0] src_base, dst_base;
  logic [IDX_W-1:0]  cnt_q;
  logic [MODE_W-1:0] mode;
  logic              go, clr, ctrl_wr;
  logic [1:0]        rot;
  logic [1:0]        rsel;
  logic [15:0]       rnd;

  logic [NUM_CH-1:0]             fire_a, fin_a, full_a, vld_a;
  logic [ADDR_W-1:0]             base_a [NUM_CH];
  logic [ADDR_W-1:0]             addr_a [NUM_CH];
  logic [GAP_W-1:0]              seed_a [NUM_CH];

  assign rsel    = mode[MODE_RSEL +: 2];
  assign ctrl_wr = cfg_we && (cfg_sel == SEL_CTRL);
  assign clr     = ctrl_wr && cfg_wdata[0] && !go;

  assign full_a[0] = rd_full;
  assign full_a[1] = wr_full;
  assign base_a[0] = src_base;
  assign base_a[1] = dst_base;
  assign seed_a[0] = rnd[GAP_W-1:0];
  assign seed_a[1] = rnd[2*GAP_W-1:GAP_W];

  cls_lfsr #(.SEED(SEED)) u_lfsr (.clk(clk), .rst(rst), .state(rnd));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cls_chan #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ch (
      .clk(clk), .rst(rst), .go(go), .clr(clr),
      .wrap(mode[MODE_WRAP]), .full(full_a[c]), .dly_en(mode[MODE_DLY]),
      .gap_seed(seed_a[c]), .base(base_a[c]), .cnt(cnt_q),
      .fire(fire_a[c]), .req_v(vld_a[c]), .req_addr(addr_a[c]), .fin(fin_a[c])
    );
  end

  assign rd_valid = vld_a[0];
  assign wr_valid = vld_a[1];
  assign rd_addr  = addr_a[0];
  assign wr_addr  = addr_a[1];

  // Configuration registers: writable only while idle
  always_ff @(posedge clk) begin
    if (rst) begin
      src_base <= '0;
      dst_base <= '0;
      cnt_q    <= '0;
      mode     <= '0;
    end else if (cfg_we && !go) begin
      case (cfg_sel)
        SEL_SRC:  src_base <= cfg_wdata & ~LOW_MASK;
        SEL_DST:  dst_base <= cfg_wdata & ~LOW_MASK;
        SEL_CNT:  cnt_q    <= cfg_wdata[IDX_W-1:0];
        SEL_MODE: mode     <= cfg_wdata[MODE_W-1:0];
        default: ;
      endcase
    end
  end

  // Run control and completion
  always_ff @(posedge clk) begin
    if (rst) begin
      go   <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && halt_err) begin
        go <= 1'b0;
      end else if (go && (&fin_a) && !mode[MODE_WRAP]) begin
        go   <= 1'b0;
        done <= 1'b1;
      end
      if (ctrl_wr) go <= cfg_wdata[0];
    end
  end

  // Request types
  always_ff @(posedge clk) begin
    if (rst) begin
      rot     <= '0;
      rd_type <= RD_SHARED;
      wr_type <= 1'b0;
    end else begin
      if (clr) begin
        rot <= '0;
      end else if (fire_a[0]) begin
        rd_type <= (rsel == RD_MIXED) ? rot : rsel;
        if (rsel == RD_MIXED) rot <= (rot == 2'd2) ? 2'd0 : rot + 1'b1;
      end
      if (fire_a[1]) wr_type <= mode[MODE_WT];
    end
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !go |=> (!rd_valid && !wr_valid));
  assert_mixed_legal_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_type != RD_MIXED));
  assert_cfg_lock_R9: assert property (@(posedge clk) disable iff (rst)
    go |=> ($stable(src_base) && $stable(dst_base) && $stable(cnt_q) && $stable(mode)));
endmodule

// File: tb/cls_seq_test.sv
module cls_seq_test;
  localparam int LOG = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        rd_full = 1'b0, wr_full = 1'b0, halt_err = 1'b0;
  logic        rd_valid, wr_valid, wr_type, done;
  logic [31:0] rd_addr, wr_addr;
  logic [1:0]  rd_type;

  cls_seq uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_full(rd_full), .wr_full(wr_full), .halt_err(halt_err),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_type(rd_type),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_type(wr_type), .done(done)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int rd_n, wr_n, done_n, stall_bad;
  logic [31:0] rd_a [LOG];
  logic [31:0] wr_a [LOG];
  logic [1:0]  rd_t [LOG];
  logic        wr_t [LOG];
  int          rd_c [LOG];
  int          wr_c [LOG];
  logic        rd_full_prev = 1'b0, wr_full_prev = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rd_valid) begin
      if (rd_n < LOG) begin rd_a[rd_n] = rd_addr; rd_t[rd_n] = rd_type; rd_c[rd_n] = cyc; end
      if (rd_full_prev) stall_bad = stall_bad + 1;
      rd_n = rd_n + 1;
    end
    if (wr_valid) begin
      if (wr_n < LOG) begin wr_a[wr_n] = wr_addr; wr_t[wr_n] = wr_type; wr_c[wr_n] = cyc; end
      if (wr_full_prev) stall_bad = stall_bad + 1;
      wr_n = wr_n + 1;
    end
    if (done) done_n = done_n + 1;
    rd_full_prev = rd_full;
    wr_full_prev = wr_full;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic cfg(input logic [2:0] s, input logic [31:0] d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic clear_logs();
    rd_n = 0; wr_n = 0; done_n = 0; stall_bad = 0;
  endtask

  task automatic setup(input logic [31:0] src, input logic [31:0] dst,
                       input logic [31:0] count, input logic [31:0] mode);
    cfg(3'd0, src); cfg(3'd1, dst); cfg(3'd2, count); cfg(3'd3, mode);
  endtask

  task automatic start();
    clear_logs();
    cfg(3'd4, 32'd1);
  endtask

  localparam logic [31:0] SRC = 32'h0004_0000;
  localparam logic [31:0] DST = 32'h0008_0000;

  task automatic t_reset();
    tick(3);
    check(!rd_valid && !wr_valid && !done, "R1 outputs in reset", {rd_valid, wr_valid, done}, 0);
    rst = 1'b0;
    tick(1);
    check(!rd_valid && !wr_valid && !done, "R1 outputs after reset", {rd_valid, wr_valid, done}, 0);
  endtask

  task automatic t_basic();
    setup(SRC, DST, 5, 32'h0);
    start();
    tick(20);
    check(rd_n == 5, "R2 read count", rd_n, 5);
    check(wr_n == 5, "R2 write count", wr_n, 5);
    for (int i = 0; i < 5; i++) begin
      check(rd_a[i] == (SRC | i), "R2 read address", rd_a[i], SRC | i);
      check(wr_a[i] == (DST | i), "R2 write address", wr_a[i], DST | i);
      check(rd_t[i] == 2'd0, "R6 read type shared", rd_t[i], 0);
      check(wr_t[i] == 1'b0, "R7 write-back type", wr_t[i], 0);
    end
    check(rd_c[4] - rd_c[0] == 4, "R2 back-to-back reads", rd_c[4] - rd_c[0], 4);
    check(done_n == 1, "R4 single done pulse", done_n, 1);
    tick(5);
    check(rd_n == 5 && wr_n == 5, "R4 no requests after done", rd_n + wr_n, 10);
  endtask

  task automatic t_stall();
    setup(SRC, DST, 8, 32'h0);
    start();
    tick(2);
    rd_full = 1'b1;
    tick(4);
    rd_full = 1'b0;
    tick(20);
    check(rd_n == 8, "R3 read count after stall", rd_n, 8);
    for (int i = 0; i < 8; i++)
      check(rd_a[i] == (SRC | i), "R3 index held during stall", rd_a[i], SRC | i);
    check(rd_c[7] - rd_c[0] == 11, "R3 read span with 4 stalled edges", rd_c[7] - rd_c[0], 11);
    check(wr_c[7] - wr_c[0] == 7, "R3 write channel independent", wr_c[7] - wr_c[0], 7);
    check(stall_bad == 0, "R3 request after full edge", stall_bad, 0);
    check(done_n == 1, "R4 done after stalled run", done_n, 1);
  endtask

  task automatic t_types();
    setup(SRC, DST, 6, (32'd3 << 3) | 32'h2);
    start();
    tick(20);
    check(rd_n == 6, "R6 mixed read count", rd_n, 6);
    for (int i = 0; i < 6; i++) begin
      check(rd_t[i] == 2'(i % 3), "R6 mixed rotation", rd_t[i], i % 3);
      check(wr_t[i] == 1'b1, "R7 write-through type", wr_t[i], 1);
    end
    setup(SRC, DST, 2, (32'd2 << 3));
    start();
    tick(10);
    for (int i = 0; i < 2; i++) begin
      check(rd_t[i] == 2'd2, "R6 owned type", rd_t[i], 2);
      check(wr_t[i] == 1'b0, "R7 write-back type", wr_t[i], 0);
    end
  endtask

  task automatic t_wrap();
    setup(SRC, DST, 3, 32'h1);
    start();
    tick(10);
    cfg(3'd4, 32'd0);
    tick(5);
    check(rd_n == 12, "R5 reads until start cleared", rd_n, 12);
    check(wr_n == 12, "R5 writes until start cleared", wr_n, 12);
    for (int i = 0; i < 12; i++)
      check(rd_a[i] == (SRC | (i % 3)), "R5 wrap address", rd_a[i], SRC | (i % 3));
    check(done_n == 0, "R5 no done in wrap mode", done_n, 0);
  endtask

  task automatic t_lock();
    setup(SRC, DST, 10, 32'h0);
    start();
    cfg(3'd0, 32'h00C0_0000);
    cfg(3'd2, 32'd2);
    tick(20);
    check(rd_n == 10, "R9 count write ignored while running", rd_n, 10);
    for (int i = 0; i < 10; i++)
      check(rd_a[i] == (SRC | i), "R9 base write ignored while running", rd_a[i], SRC | i);
  endtask

  task automatic t_mask();
    setup(SRC | 32'h1234, DST | 32'h3FFF, (32'd1 << 14) | 32'd3, 32'h0);
    start();
    tick(12);
    check(rd_n == 3, "R10 count upper bits ignored", rd_n, 3);
    for (int i = 0; i < 3; i++) begin
      check(rd_a[i] == (SRC | i), "R10 source low bits ignored", rd_a[i], SRC | i);
      check(wr_a[i] == (DST | i), "R10 destination low bits ignored", wr_a[i], DST | i);
    end
  endtask

  task automatic t_zero();
    setup(SRC, DST, 0, 32'h0);
    start();
    tick(8);
    check(rd_n == 0 && wr_n == 0, "R11 no requests for zero count", rd_n + wr_n, 0);
    check(done_n == 1, "R11 done for zero count", done_n, 1);
  endtask

  task automatic t_fault();
    setup(SRC, DST, 20, 32'h0);
    start();
    tick(3);
    halt_err = 1'b1;
    tick(1);
    halt_err = 1'b0;
    tick(10);
    check(rd_n == 4, "R12 reads stop after error", rd_n, 4);
    check(wr_n == 4, "R12 writes stop after error", wr_n, 4);
    check(done_n == 0, "R12 no done on error", done_n, 0);
  endtask

  task automatic t_delay();
    int mx, gaps;
    setup(SRC, DST, 20, 32'h4);
    start();
    tick(250);
    check(rd_n == 20, "R8 read count with delay", rd_n, 20);
    check(wr_n == 20, "R8 write count with delay", wr_n, 20);
    mx = 0; gaps = 0;
    for (int i = 0; i < 19; i++) begin
      int g;
      g = rd_c[i+1] - rd_c[i] - 1;
      if (g > mx) mx = g;
      if (g > 0) gaps++;
      g = wr_c[i+1] - wr_c[i] - 1;
      if (g > mx) mx = g;
      if (g > 0) gaps++;
      check(rd_a[i+1] == (SRC | (i + 1)), "R8 address order with delay", rd_a[i+1], SRC | (i + 1));
    end
    check(mx <= 7, "R8 gap at most 7", mx, 7);
    check(gaps > 0, "R8 some gaps inserted", gaps, 1);
    check(done_n == 1, "R8 done with delay", done_n, 1);
  endtask

  bit finished = 1'b0;

  initial begin
    clear_logs();
    t_reset();
    t_basic();
    t_stall();
    t_types();
    t_wrap();
    t_lock();
    t_mask();
    t_zero();
    t_fault();
    t_delay();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule